// File: doc/BRIEF.md
# Daisy-Chainable 24-Bit Serial Frame Engine

This block is the serial front end of a multi-channel control device. A host shifts 24-bit command words in on a serial data line while chip select is low. When chip select rises after a whole number of words, the engine hands the word to the command logic as a one-cycle strobe in the system clock domain. Command decoding happens outside this block.

One 24-bit register both captures input bits and feeds the serial output. While a new word shifts in, the previously held word shifts out. Devices can therefore be wired output-to-input in a chain, and a longer burst leaves only its last word in the first device. The command logic can place a read-back word into the same register between frames, and that word then appears on the serial output during the next command.

The three serial pins are sampled by the system clock through a synchronizer. All edge detection happens in that single clock domain. The output is open-drain style: a data bit plus an enable that is active only while chip select is low.

Top module: `sfe_frame_engine`

## Requirements
- R1: While reset is held and directly after it, `frame_vld` is 0, `spi_sdo_oe` is 0, `frame_word` is all zeros and the held word is all zeros.
- R2: `spi_sdo_oe` is 1 while the synchronized chip select is low and 0 (output released) while it is high.
- R3: Bits on `spi_sdi` are taken at each rising SCLK edge, most significant bit first. After exactly 24 such edges and the rise of chip select, `frame_word` holds them with the first bit in bit 23. Bits [23:20] are the opcode, [19:16] the address, [15:9] unused, [8] the extension bit and [7:0] the data value; all pass through unchanged.
- R4: `frame_vld` is a single system-clock pulse that comes at most 6 clock cycles after chip select rises at the pin. It is never high while `spi_sdo_oe` is 1.
- R5: When the number of rising SCLK edges during chip select low is zero or not a multiple of 24, no strobe is issued and `frame_word` keeps its value.
- R6: When that number is 48 or a larger multiple of 24, one strobe is issued and `frame_word` holds the last 24 bits received.
- R7: The held word is always the last 24 bits of the stream formed by the previous held word followed by the received bits. When chip select falls, SDO shows bit 23 of the held word before the first rising SCLK edge. Each falling SCLK edge advances SDO to the next bit of that stream.
- R8: In a 48-bit burst, SDO first emits the word held before the burst and then the first 24 bits received, which passes them to the next device in a chain.
- R9: A pulse on `rdbk_load` while chip select is high replaces the held word with `rdbk_word`. That word then leaves on SDO, MSB first, during the next frame.
- R10: A pulse on `rdbk_load` while chip select is low has no effect on the SDO bits of that frame or on the word captured at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, asynchronous to `clk` |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out (value) |
| spi_sdo_oe | output | 1 | Drive enable for SDO; 0 means high-impedance |
| frame_vld | output | 1 | One-cycle strobe: a complete word is in `frame_word` |
| frame_word | output | 24 | Last accepted command word |
| rdbk_load | input | 1 | Load `rdbk_word` into the held word (honoured only while chip select is high) |
| rdbk_word | input | 24 | Read-back word from the command logic |

## Verification
The assertions assume the serial pins are slow next to `clk`. They expect each SCLK phase to last at least three system cycles, SDI to stay steady across the sampled rising edge, chip select to change only while SCLK is low and to stay high for several cycles, and `rdbk_load` to be a single-cycle pulse. The bench keeps to these limits: it changes every pin on a falling `clk` edge and holds each SCLK phase for four cycles. It also waits four cycles after each chip select edge and leaves chip select high for twelve cycles between frames.

// File: rtl/sfe_pkg.sv
// Shared types and constants for the serial frame engine.
// Assumes nothing beyond a single system clock domain for every user.
package sfe_pkg;

    // Default command word width
    localparam int unsigned SFE_FRAME_W = 24;

    // Raw serial pins grouped for synchronization
    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic sdi;
    } sfe_pins_t;

    // Idle value of the pins: clock low, deselected
    localparam sfe_pins_t SFE_PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, sdi: 1'b0};

    // Single-cycle events derived from the synchronized pins
    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_fall;
        logic cs_rise;
        logic cs_low;
        logic sdi;
    } sfe_evt_t;

endpackage

// File: rtl/sfe_sync.sv
// Multi-stage flop synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent or is sampled together with the other
// bits only where the surrounding protocol keeps them steady.
module sfe_sync #(
    parameter int unsigned         WIDTH   = 1,
    parameter int unsigned         STAGES  = 2,
    parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] q_r;
            if (g == 0) begin : g_first
                // First stage captures the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) q_r <= RST_VAL;
                    else        q_r <= d;
                end
            end else begin : g_next
                // Later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) q_r <= RST_VAL;
                    else        q_r <= g_stage[g-1].q_r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/sfe_edge.sv
// Turns synchronized serial pins into single-cycle events.
// SCLK edges are only reported while chip select is low, so a clock
// toggling on a shared bus is ignored while this device is deselected.
module sfe_edge
    import sfe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sfe_pins_t pins_s,
    output sfe_evt_t  evt
);

    sfe_pins_t prev_q;

    // Keep last cycle's pin values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= SFE_PINS_IDLE;
        else        prev_q <= pins_s;
    end

    // Compare current and previous samples
    always_comb begin
        evt.cs_low    = ~pins_s.cs_n;
        evt.cs_fall   =  prev_q.cs_n & ~pins_s.cs_n;
        evt.cs_rise   = ~prev_q.cs_n &  pins_s.cs_n;
        evt.sclk_rise =  pins_s.sclk & ~prev_q.sclk & ~pins_s.cs_n;
        evt.sclk_fall = ~pins_s.sclk &  prev_q.sclk & ~pins_s.cs_n;
        evt.sdi       =  pins_s.sdi;
    end

endmodule

// File: rtl/sfe_bitcount.sv
// Counts received bits modulo the word width during one chip-select window.
// frame_ok is true when at least one bit arrived and the count is a whole
// number of words. Assumes chip select falls before the first SCLK edge.
module sfe_bitcount
    import sfe_pkg::*;
#(
    parameter int unsigned FRAME_W = SFE_FRAME_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  sfe_evt_t evt,
    output logic     frame_ok
);

    localparam int unsigned CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;

    // Clear at the start of a window, advance on each sampled bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (evt.cs_fall) begin
            cnt_q  <= evt.sclk_rise ? CNT_W'(1) : '0;
            seen_q <= evt.sclk_rise;
        end else if (evt.sclk_rise) begin
            cnt_q  <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
            seen_q <= 1'b1;
        end
    end

    // Whole, non-empty word count
    assign frame_ok = seen_q && (cnt_q == '0);

endmodule

// File: rtl/sfe_shifter.sv
// Shared capture/transmit register. Input bits shift in at the LSB on each
// sampled rising SCLK edge. The output bit is refreshed from the MSB on chip
// select fall and on each falling SCLK edge. A parallel read-back load is
// accepted only while the device is deselected.
module sfe_shifter
    import sfe_pkg::*;
#(
    parameter int unsigned FRAME_W = SFE_FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sfe_evt_t           evt,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] load_word,
    output logic [FRAME_W-1:0] held_word,
    output logic               sdo_bit
);

    logic [FRAME_W-1:0] sr_q;
    logic               sdo_q;

    // Shift in new bits or take a read-back word while idle
    always_ff @(posedge clk) begin
        if (!rst_n)                        sr_q <= '0;
        else if (evt.sclk_rise)            sr_q <= {sr_q[FRAME_W-2:0], evt.sdi};
        else if (load_en && !evt.cs_low)   sr_q <= load_word;
    end

    // Present the next outgoing bit on the falling edges
    always_ff @(posedge clk) begin
        if (!rst_n)                             sdo_q <= 1'b0;
        else if (evt.cs_fall || evt.sclk_fall)  sdo_q <= sr_q[FRAME_W-1];
    end

    assign held_word = sr_q;
    assign sdo_bit   = sdo_q;

endmodule

// File: rtl/sfe_frame_engine.sv
// Top of the serial frame engine. Synchronizes the serial pins to clk,
// derives edge events, shifts words through one register and, on chip select
// rise after a whole number of words, publishes the held word with a strobe.
// Assumes SCLK phases of at least three clk cycles.
module sfe_frame_engine
    import sfe_pkg::*;
#(
    parameter int unsigned FRAME_W     = SFE_FRAME_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_sdi,
    output logic               spi_sdo,
    output logic               spi_sdo_oe,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_word,
    input  logic               rdbk_load,
    input  logic [FRAME_W-1:0] rdbk_word
);

    localparam int unsigned PIN_W = $bits(sfe_pins_t);

    sfe_pins_t          pins_raw;
    sfe_pins_t          pins_s;
    sfe_evt_t           evt;
    logic               frame_ok;
    logic [FRAME_W-1:0] held_word;
    logic               sdo_bit;
    logic               sclk_rise_w;
    logic               sclk_fall_w;
    logic               cs_fall_w;
    logic               vld_q;
    logic [FRAME_W-1:0] word_q;

    assign pins_raw = '{sclk: spi_sclk, cs_n: spi_cs_n, sdi: spi_sdi};

    sfe_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SFE_PINS_IDLE)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    sfe_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_s (pins_s),
        .evt    (evt)
    );

    sfe_bitcount #(
        .FRAME_W (FRAME_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .frame_ok (frame_ok)
    );

    sfe_shifter #(
        .FRAME_W (FRAME_W)
    ) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .load_en   (rdbk_load),
        .load_word (rdbk_word),
        .held_word (held_word),
        .sdo_bit   (sdo_bit)
    );

    // Publish the held word when a valid window closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            word_q <= '0;
        end else begin
            vld_q <= evt.cs_rise && frame_ok;
            if (evt.cs_rise && frame_ok) word_q <= held_word;
        end
    end

    assign sclk_rise_w = evt.sclk_rise;
    assign sclk_fall_w = evt.sclk_fall;
    assign cs_fall_w   = evt.cs_fall;

    assign spi_sdo    = sdo_bit;
    assign spi_sdo_oe = evt.cs_low;
    assign frame_vld  = vld_q;
    assign frame_word = word_q;

endmodule

// File: rtl/sfe_frame_engine_chk.sv
// Assertion checker for the serial frame engine, bound to the top module.
// Assumes the input timing limits listed in the brief.
module sfe_frame_engine_chk #(
    parameter int unsigned FRAME_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_vld,
    input logic [FRAME_W-1:0] frame_word,
    input logic               spi_sdo,
    input logic               spi_sdo_oe,
    input logic               rdbk_load,
    input logic [FRAME_W-1:0] rdbk_word,
    input logic [FRAME_W-1:0] held_word,
    input logic               sclk_rise,
    input logic               sclk_fall,
    input logic               cs_fall
);

    // R4: strobe lasts one cycle
    a_r4_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);

    // R4: strobe only while deselected
    a_r4_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> !spi_sdo_oe);

    // R3 / R5: the published word changes only together with the strobe
    a_r3_word_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_word != $past(frame_word)) |-> frame_vld);

    // R7: SDO moves only after a chip select fall or a falling SCLK edge
    a_r7_sdo_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sdo != $past(spi_sdo)) |-> $past(sclk_fall || cs_fall));

    // R9: an idle load replaces the held word
    a_r9_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (rdbk_load && !spi_sdo_oe) |=> (held_word == $past(rdbk_word)));

    // R10: a load during a frame leaves the held word alone
    a_r10_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rdbk_load && spi_sdo_oe && !sclk_rise) |=> (held_word == $past(held_word)));

endmodule

bind sfe_frame_engine sfe_frame_engine_chk #(
    .FRAME_W (FRAME_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_vld  (frame_vld),
    .frame_word (frame_word),
    .spi_sdo    (spi_sdo),
    .spi_sdo_oe (spi_sdo_oe),
    .rdbk_load  (rdbk_load),
    .rdbk_word  (rdbk_word),
    .held_word  (held_word),
    .sclk_rise  (sclk_rise_w),
    .sclk_fall  (sclk_fall_w),
    .cs_fall    (cs_fall_w)
);

// File: tb/sfe_frame_engine_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected SDO bits and expected words
// into queues; monitors pop and compare them as the design produces them.
module sfe_frame_engine_tb_top;

    typedef struct {
        logic  b;
        string tag;
    } exp_bit_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sdi = 1'b0;
    logic        spi_sdo;
    logic        spi_sdo_oe;
    logic        frame_vld;
    logic [23:0] frame_word;
    logic        rdbk_load = 1'b0;
    logic [23:0] rdbk_word = '0;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;
    logic [23:0] model    = '0;
    logic [23:0] last_ok  = '0;
    logic        vld_prev = 1'b0;
    exp_bit_t    bit_q[$];
    logic [23:0] word_q[$];
    string       wtag_q[$];
    exp_bit_t    e;
    logic [23:0] w;
    string       t;

    always #2.5 clk = ~clk;

    sfe_frame_engine dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_sdi    (spi_sdi),
        .spi_sdo    (spi_sdo),
        .spi_sdo_oe (spi_sdo_oe),
        .frame_vld  (frame_vld),
        .frame_word (frame_word),
        .rdbk_load  (rdbk_load),
        .rdbk_word  (rdbk_word)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one chip-select window of nbits, optional load mid-frame
    task automatic send(input int nbits, input logic [95:0] stream,
                        input string sdo_tag, input string word_tag,
                        input int load_at, input logic [23:0] load_val);
        exp_bit_t x;
        spi_cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            spi_sdi = stream[nbits-1-i];
            x.b   = model[23];
            x.tag = sdo_tag;
            bit_q.push_back(x);
            model = {model[22:0], stream[nbits-1-i]};
            if (i == load_at) begin
                rdbk_word = load_val;
                rdbk_load = 1'b1;
                tick(1);
                rdbk_load = 1'b0;
                tick(3);
            end else begin
                tick(4);
            end
            spi_sclk = 1'b1;
            tick(4);
            spi_sclk = 1'b0;
        end
        if (nbits > 0 && nbits % 24 == 0) begin
            word_q.push_back(model);
            wtag_q.push_back(word_tag);
            last_ok = model;
        end
        tick(4);
        spi_cs_n = 1'b1;
        tick(12);
        check(spi_sdo_oe === 1'b0, "R2", "oe after deselect", spi_sdo_oe, 0);
        check(word_q.size() == 0, "R4", "strobe pending after 12 cycles", word_q.size(), 0);
        check(frame_word === last_ok, word_tag, "word after window", frame_word, last_ok);
    endtask

    // Idle read-back load
    task automatic load_idle(input logic [23:0] v);
        rdbk_word = v;
        rdbk_load = 1'b1;
        tick(1);
        rdbk_load = 1'b0;
        model = v;
        tick(4);
    endtask

    // Monitor: SDO bit at each rising SCLK
    always @(posedge spi_sclk) begin
        if (bit_q.size() == 0) begin
            check(1'b0, "R7", "unexpected sclk edge", 0, 0);
        end else begin
            e = bit_q.pop_front();
            check(spi_sdo === e.b, e.tag, "sdo bit", spi_sdo, e.b);
            check(spi_sdo_oe === 1'b1, "R2", "oe during frame", spi_sdo_oe, 1);
        end
    end

    // Monitor: frame strobes and words
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_vld) begin
                check(!vld_prev, "R4", "strobe wider than one cycle", 1, 0);
                if (!vld_prev) begin
                    if (word_q.size() == 0) begin
                        check(1'b0, "R5", "unexpected strobe", frame_word, 0);
                    end else begin
                        w = word_q.pop_front();
                        t = wtag_q.pop_front();
                        check(frame_word === w, t, "frame word", frame_word, w);
                    end
                end
            end
            vld_prev = frame_vld;
        end
    end

    initial begin
        tick(5);
        check(frame_vld === 1'b0, "R1", "strobe in reset", frame_vld, 0);
        check(spi_sdo_oe === 1'b0, "R1", "oe in reset", spi_sdo_oe, 0);
        check(frame_word === 24'h0, "R1", "word in reset", frame_word, 0);
        rst_n = 1'b1;
        tick(5);
        check(frame_word === 24'h0, "R1", "word after reset", frame_word, 0);

        send(24, 96'hA5C31E, "R7", "R3", -1, '0);
        send(24, 96'h3C0F81, "R7", "R3", -1, '0);
        send(48, {48'h0, 24'h123456, 24'hFEDCBA}, "R8", "R6", -1, '0);
        send(23, 96'h7ABCDE, "R7", "R5", -1, '0);
        send(25, 96'h1555AAA, "R7", "R5", -1, '0);
        send(0, 96'h0, "R7", "R5", -1, '0);
        send(24, 96'h0F0F0F, "R7", "R3", -1, '0);
        load_idle(24'h5AA5F0);
        send(24, 96'h000000, "R9", "R3", -1, '0);
        send(24, 96'hC3C3C3, "R10", "R10", 10, 24'hFFFFFF);
        send(24, 96'h000000, "R10", "R3", -1, '0);
        send(72, {24'h0, 24'h111111, 24'h222222, 24'h9A8B7C}, "R8", "R6", -1, '0);
        load_idle(24'h800001);
        send(24, 96'hFFFFFF, "R9", "R3", -1, '0);

        check(bit_q.size() == 0, "R7", "sdo bits left unchecked", bit_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule